// File: doc/BRIEF.md
# Frame CRC Monitor

This block checks the content of a display pipe frame by frame. Software writes one control word that holds an enable bit, a source code and an expected signature. The block then folds every accepted data word from the chosen source into a 23-bit LFSR. It starts a fresh signature at each vertical-blank strobe and publishes the finished signature of the frame that just ended. Each published signature is compared with the expected value. A difference sets a sticky mismatch flag, which can drive an interrupt.

Ten sources can be selected. Five of them carry 30-bit words (pixel or link data), and these are zero-extended to the 40-bit datapath. The other five carry full 40-bit words, including two audio paths. The data inputs use a valid strobe with no back-pressure. A checker cannot stall a display stream, so the block accepts every beat whose valid is high and has no ready signal. After the block is switched on, or after its source is changed, the partial frame in flight is thrown away. The first signature is published only when a second vertical blank is seen.

Top module: `frame_crc_monitor`

## Requirements
- R1: After reset, `cfg_rdata`, `crc_result`, `result_valid`, `mismatch_sts` and `irq` are all zero.
- R2: A `cfg_wr` pulse loads the control word, with enable at bit 31, source code at bits 30:27 and expected signature at bits 22:0. `cfg_rdata` returns these fields, and bits 26:23 always read zero whatever was written to them.
- R3: While enable is 0, a `vblank` pulse gives no `result_valid` and the mismatch flag does not change.
- R4: The first `vblank` after warm-up starts only opens a frame, and it does not publish. The second `vblank` and each later one publish. Publishing means `result_valid` is high for the one cycle after the `vblank` cycle, and `crc_result` holds the signature of the frame that ended.
- R5: A frame signature starts as all ones at `vblank`. Each accepted 40-bit word is folded in MSB first as a Galois LFSR: for each bit, `fb = crc[22] ^ d`, then crc shifts left by one, and it is XORed with 23'h000021 when `fb` is 1. A beat in the `vblank` cycle belongs to the new frame. A beat with its valid low is not folded.
- R6: Source code n (0 to 9) takes `src_data[n]` gated by `src_valid[n]`. The data and valids of all other sources have no effect on the signature.
- R7: Codes 0, 1, 2, 4 and 5 are 30-bit sources: bits 39:30 of their words are replaced with zero before folding. Codes 3, 6, 7, 8 and 9 use all 40 bits.
- R8: Codes 10 to 15 are reserved. With one of them selected, no signature is published and no compare is made.
- R9: At each publish, a signature that differs from the expected value sets `mismatch_sts`. A matching signature leaves it unchanged. The flag stays set until it is cleared.
- R10: A `sts_clr` pulse clears `mismatch_sts`.
- R11: `irq` is high exactly when `mismatch_sts` and `irq_en` are both high.
- R12: A write that turns enable from 0 to 1, or that changes the source code while enable stays 1, restarts the warm-up of R4. A write that keeps the same code and enable and changes only the expected value does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word readback |
| vblank | input | 1 | One-cycle vertical-blank strobe |
| src_data | input | 10x40 | Data words of all sources, indexed by source code |
| src_valid | input | 10 | Valid strobe per source |
| irq_en | input | 1 | Interrupt enable |
| sts_clr | input | 1 | Write-one-to-clear pulse for the mismatch flag |
| crc_result | output | 23 | Last published frame signature |
| result_valid | output | 1 | One-cycle pulse when a signature is published |
| mismatch_sts | output | 1 | Sticky mismatch flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: ten sources, a 40-bit datapath with 30-bit narrow sources, and a 23-bit signature. It sweeps all sixteen source codes. Each source gets its own data pattern and every word has nonzero upper bits, so the zero-extension of the narrow codes, the isolation of unselected sources and the silence of the reserved codes all show up at the outputs. On every valid code it runs warm-up, matching and mismatching frames, flag clearing, a rewrite of the expected value and disabling. A separate pass covers the restart that follows a change of source.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
  localparam int REG_W    = 32;
  localparam int EN_BIT   = 31;
  localparam int SEL_LSB  = 27;
  localparam int SEL_W    = 4;
  localparam int RSV_LSB  = 23;
  localparam int RSV_W    = 4;
  localparam int EXP_W    = 23;

  localparam int NUM_SRC  = 10;
  localparam int WORD_W   = 40;
  localparam int NARROW_W = 30;
  // sources whose words are only NARROW_W bits wide
  localparam logic [NUM_SRC-1:0] NARROW_SRC_MASK = 10'b00_0011_0111;
  localparam logic [EXP_W-1:0]   CRC_POLY        = 23'h000021;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
    logic [EXP_W-1:0] expv;
  } ctrl_t;
endpackage

// File: rtl/fcm_cfg_reg.sv
module fcm_cfg_reg
  import fcm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output ctrl_t            ctrl,
  output logic             restart,
  output logic [REG_W-1:0] rdata
);
  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic  unused_rsv;

  assign unused_rsv  = ^wdata[RSV_LSB +: RSV_W];
  assign ctrl_d.en   = wdata[EN_BIT];
  assign ctrl_d.sel  = wdata[SEL_LSB +: SEL_W];
  assign ctrl_d.expv = wdata[EXP_W-1:0];

  // a fresh enable or a new source throws away the frame in flight
  assign restart = wr && ctrl_d.en && (!ctrl_q.en || (ctrl_d.sel != ctrl_q.sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr) ctrl_q <= ctrl_d;
  end

  assign ctrl  = ctrl_q;
  assign rdata = {ctrl_q.en, ctrl_q.sel, {RSV_W{1'b0}}, ctrl_q.expv};
endmodule

// File: rtl/fcm_src_mux.sv
module fcm_src_mux #(
  parameter int NUM_SRC  = 10,
  parameter int WORD_W   = 40,
  parameter int NARROW_W = 30,
  parameter int SEL_W    = 4,
  parameter logic [NUM_SRC-1:0] NARROW_MASK = '0
) (
  input  logic [NUM_SRC-1:0][WORD_W-1:0] src_data,
  input  logic [NUM_SRC-1:0]             src_valid,
  input  logic [SEL_W-1:0]               sel,
  output logic                           code_ok,
  output logic [WORD_W-1:0]              word,
  output logic                           word_vld
);
  localparam int PAD_W = WORD_W - NARROW_W;

  logic [NUM_SRC-1:0][WORD_W-1:0] shaped;
  logic [SEL_W-1:0]               idx;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_shape
    if (NARROW_MASK[s]) begin : g_narrow
      assign shaped[s] = {{PAD_W{1'b0}}, src_data[s][NARROW_W-1:0]};
    end else begin : g_wide
      assign shaped[s] = src_data[s];
    end
  end

  assign code_ok  = (32'(sel) < NUM_SRC);
  assign idx      = code_ok ? sel : '0;
  assign word     = shaped[idx];
  assign word_vld = code_ok && src_valid[idx];
endmodule

// File: rtl/fcm_crc_acc.sv
module fcm_crc_acc #(
  parameter int CRC_W  = 23,
  parameter int WORD_W = 40,
  parameter logic [CRC_W-1:0] POLY = 23'h000021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              frame_start,
  input  logic              beat,
  input  logic [WORD_W-1:0] data,
  output logic [CRC_W-1:0]  crc
);
  localparam logic [CRC_W-1:0] SEED = '1;

  function automatic logic [CRC_W-1:0] fold(input logic [CRC_W-1:0] c_in,
                                            input logic [WORD_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = c_in;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return c;
  endfunction

  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= SEED;
    else if (active) begin
      if (frame_start) crc_q <= beat ? fold(SEED, data) : SEED;
      else if (beat)   crc_q <= fold(crc_q, data);
    end
  end

  assign crc = crc_q;
endmodule

// File: rtl/frame_crc_monitor.sv
module frame_crc_monitor
  import fcm_pkg::*;
#(
  parameter int CRC_W = EXP_W,
  parameter int N_SRC = NUM_SRC,
  parameter int DW    = WORD_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wr,
  input  logic [REG_W-1:0]           cfg_wdata,
  output logic [REG_W-1:0]           cfg_rdata,
  input  logic                       vblank,
  input  logic [N_SRC-1:0][DW-1:0]   src_data,
  input  logic [N_SRC-1:0]           src_valid,
  input  logic                       irq_en,
  input  logic                       sts_clr,
  output logic [CRC_W-1:0]           crc_result,
  output logic                       result_valid,
  output logic                       mismatch_sts,
  output logic                       irq
);
  ctrl_t            ctrl;
  logic             restart;
  logic             code_ok;
  logic [DW-1:0]    word;
  logic             word_vld;
  logic             active;
  logic [CRC_W-1:0] crc_run;
  logic             opened_q;
  logic             publish;
  logic [CRC_W-1:0] res_q;
  logic             rv_q;
  logic             sts_q;

  fcm_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
    .ctrl(ctrl), .restart(restart), .rdata(cfg_rdata)
  );

  fcm_src_mux #(
    .NUM_SRC(N_SRC), .WORD_W(DW), .NARROW_W(NARROW_W), .SEL_W(SEL_W),
    .NARROW_MASK(NARROW_SRC_MASK)
  ) u_mux (
    .src_data(src_data), .src_valid(src_valid), .sel(ctrl.sel),
    .code_ok(code_ok), .word(word), .word_vld(word_vld)
  );

  assign active = ctrl.en && code_ok;

  fcm_crc_acc #(.CRC_W(CRC_W), .WORD_W(DW), .POLY(CRC_POLY)) u_acc (
    .clk(clk), .rst_n(rst_n), .active(active), .frame_start(vblank),
    .beat(word_vld), .data(word), .crc(crc_run)
  );

  // warm-up: first vblank only opens a frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 opened_q <= 1'b0;
    else if (restart || !active) opened_q <= 1'b0;
    else if (vblank)            opened_q <= 1'b1;
  end

  assign publish = active && vblank && opened_q && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      rv_q  <= 1'b0;
    end else begin
      rv_q <= publish;
      if (publish) res_q <= crc_run;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  sts_q <= 1'b0;
    else if (publish && (crc_run != ctrl.expv))  sts_q <= 1'b1;
    else if (sts_clr)                            sts_q <= 1'b0;
  end

  assign crc_result   = res_q;
  assign result_valid = rv_q;
  assign mismatch_sts = sts_q;
  assign irq          = sts_q && irq_en;
endmodule

// File: rtl/fcm_chk.sv
module fcm_chk #(
  parameter int CRC_W = 23
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vblank,
  input logic             sts_clr,
  input logic             irq_en,
  input logic [31:0]      cfg_rdata,
  input logic [CRC_W-1:0] crc_result,
  input logic             result_valid,
  input logic             mismatch_sts,
  input logic             irq
);
  // R4
  pub_after_vblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(vblank));

  // R3
  pub_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(cfg_rdata[31]));

  // R8
  pub_valid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> ($past(cfg_rdata[30:27]) < 4'd10));

  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(crc_result));

  // R9
  sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch_sts && !sts_clr) |=> mismatch_sts);

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && mismatch_sts));
endmodule

bind frame_crc_monitor fcm_chk #(.CRC_W(CRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vblank(vblank), .sts_clr(sts_clr),
  .irq_en(irq_en), .cfg_rdata(cfg_rdata), .crc_result(crc_result),
  .result_valid(result_valid), .mismatch_sts(mismatch_sts), .irq(irq)
);

// File: tb/frame_crc_monitor_tb.sv
`timescale 1ns/1ps
module frame_crc_monitor_tb;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_wr = 1'b0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       cfg_rdata;
  logic              vblank = 1'b0;
  logic [9:0][39:0]  src_data = '0;
  logic [9:0]        src_valid = '0;
  logic              irq_en = 1'b0;
  logic              sts_clr = 1'b0;
  logic [22:0]       crc_result;
  logic              result_valid;
  logic              mismatch_sts;
  logic              irq;

  int n_vec = 0;
  int n_bad = 0;
  int fno   = 0;

  always #2.5 clk = ~clk;

  frame_crc_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .vblank(vblank), .src_data(src_data),
    .src_valid(src_valid), .irq_en(irq_en), .sts_clr(sts_clr),
    .crc_result(crc_result), .result_valid(result_valid),
    .mismatch_sts(mismatch_sts), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [39:0] wgen(int s, int f, int b);
    logic [63:0] x;
    x = (64'(s + 1) * 64'h9E3779B97F4A7C15) ^ (64'(f + 7) * 64'hC2B2AE3D27D4EB4F)
      ^ (64'(b + 1) * 64'h165667B19E3779F9);
    return x[63:24] | 40'h80_0000_0000;
  endfunction

  function automatic bit is_narrow(int c);
    return (c == 0) || (c == 1) || (c == 2) || (c == 4) || (c == 5);
  endfunction

  function automatic logic [22:0] ref_frame(int c, int f);
    logic [22:0] r;
    logic [39:0] d;
    logic        fb;
    r = '1;
    for (int b = 0; b < 5; b++) begin
      if (b != 3) begin
        d = wgen(c, f, b);
        if (is_narrow(c)) d[39:30] = '0;
        for (int i = 39; i >= 0; i--) begin
          fb = r[22] ^ d[i];
          r  = {r[21:0], 1'b0} ^ (fb ? 23'h000021 : 23'h0);
        end
      end
    end
    return r;
  endfunction

  task automatic wr(input logic [31:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  // beat 0 carries vblank; outputs sampled one cycle later
  task automatic run_frame(output logic rv, output logic [22:0] crc,
                           output logic sts, output logic iq);
    int f;
    f = fno;
    fno++;
    for (int b = 0; b < 5; b++) begin
      for (int s = 0; s < 10; s++) src_data[s] = wgen(s, f, b);
      src_valid = (b != 3) ? 10'h3FF : 10'h000;
      vblank    = (b == 0);
      @(negedge clk);
      if (b == 0) begin
        rv = result_valid; crc = crc_result; sts = mismatch_sts; iq = irq;
      end
    end
    src_valid = '0; vblank = 1'b0;
  endtask

  task automatic run_code(int c);
    logic        rv, sts, iq;
    logic [22:0] crc, ra, rb, rc;
    string       dtag;
    dtag = is_narrow(c) ? "R7" : "R6";
    irq_en = c[0];
    ra = ref_frame(c, fno);
    rb = ref_frame(c, fno + 1);
    rc = ref_frame(c, fno + 2);
    wr({1'b1, 4'(c), 4'hF, ra});
    chk(cfg_rdata == {1'b1, 4'(c), 4'h0, ra}, "R2 readback", 64'(cfg_rdata),
        64'({1'b1, 4'(c), 4'h0, ra}));
    run_frame(rv, crc, sts, iq);
    chk(rv == 1'b0, "R4 warm-up first vblank", 64'(rv), 0);
    run_frame(rv, crc, sts, iq);
    chk(rv == 1'b1, "R4 second vblank publishes", 64'(rv), 1);
    chk(crc == ra, {dtag, " R5 frame signature"}, 64'(crc), 64'(ra));
    chk(sts == 1'b0, "R9 match keeps flag", 64'(sts), 0);
    run_frame(rv, crc, sts, iq);
    chk(rv == 1'b1 && crc == rb, {dtag, " R4 next frame"}, 64'(crc), 64'(rb));
    chk(sts == (ra != rb), "R9 mismatch sets flag", 64'(sts), 64'(ra != rb));
    chk(iq == (c[0] && (ra != rb)), "R11 irq gating", 64'(iq), 64'(c[0] && (ra != rb)));
    sts_clr = 1'b1;
    @(negedge clk);
    sts_clr = 1'b0;
    chk(mismatch_sts == 1'b0 && irq == 1'b0, "R10 clear", 64'(mismatch_sts), 0);
    wr({1'b1, 4'(c), 4'h0, rc});
    run_frame(rv, crc, sts, iq);
    chk(rv == 1'b1 && crc == rc, "R12 expected rewrite no restart", 64'(crc), 64'(rc));
    chk(sts == 1'b0, "R12 rewritten expected matches", 64'(sts), 0);
    wr({1'b0, 4'(c), 4'h0, 23'h0});
    run_frame(rv, crc, sts, iq);
    chk(rv == 1'b0, "R3 disabled no publish", 64'(rv), 0);
    run_frame(rv, crc, sts, iq);
    chk(rv == 1'b0 && sts == 1'b0, "R3 disabled no compare", 64'({rv, sts}), 0);
  endtask

  task automatic run_reserved(int c);
    logic        rv, sts, iq;
    logic [22:0] crc;
    wr({1'b1, 4'(c), 4'h0, 23'h0});
    for (int k = 0; k < 3; k++) begin
      run_frame(rv, crc, sts, iq);
      chk(rv == 1'b0 && sts == 1'b0, "R8 reserved code silent", 64'({rv, sts}), 0);
    end
    wr('0);
  endtask

  task automatic run_switch();
    logic        rv, sts, iq;
    logic [22:0] crc, r6;
    wr({1'b1, 4'd3, 4'h0, 23'h0});
    run_frame(rv, crc, sts, iq);
    run_frame(rv, crc, sts, iq);
    chk(rv == 1'b1, "R4 publish before switch", 64'(rv), 1);
    sts_clr = 1'b1;
    @(negedge clk);
    sts_clr = 1'b0;
    r6 = ref_frame(6, fno);
    wr({1'b1, 4'd6, 4'h0, r6});
    run_frame(rv, crc, sts, iq);
    chk(rv == 1'b0, "R12 switch restarts warm-up", 64'(rv), 0);
    run_frame(rv, crc, sts, iq);
    chk(rv == 1'b1 && crc == r6, "R12 new source result", 64'(crc), 64'(r6));
    chk(sts == 1'b0, "R12 new source match", 64'(sts), 0);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cfg_rdata == 32'h0, "R1 reset cfg", 64'(cfg_rdata), 0);
    chk({result_valid, mismatch_sts, irq} == 3'b0 && crc_result == '0,
        "R1 reset outputs", 64'({result_valid, mismatch_sts, irq, crc_result}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 10; c++) run_code(c);
    for (int c = 10; c < 16; c++) run_reserved(c);
    run_switch();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule